// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog. A prescaler divides the system clock by a configurable ratio (128 by default) to make counter ticks. A 12-bit counter counts down from a reload value. Software must restart it within a legal window, or a fault is recorded. Two events are faults. The first is an underflow, which happens when the counter is already at zero and another tick arrives. The second is a window error, which is a restart that arrives while the counter is still above the window value.

Each fault latches a status flag. The flags can drive an interrupt line and a reset request line. Software configures the block once through a mode register, which is locked after its first write. A restart takes effect only when the control write carries a password key. Debug and idle halt inputs can freeze counting when their mode bits allow it.

Top module: `winwdog`

## Requirements
- R1: After reset, `cnt_value` is 0xFFF, both flags are 0, and `irq` and `wdt_rst` are 0.
- R2: The counter decrements once every PRESC_DIV clocks. A tick taken while the counter is 0 sets the underflow flag and reloads the counter, so one period lasts reload+1 ticks.
- R3: A control write (`wr_sel`=0) is a restart when it has 0xA5 in bits [31:24] and bit 0 set. A restart reloads the counter and clears the prescaler.
- R4: A control write with any other key, or with bit 0 clear, is ignored. The counter and flags are not changed.
- R5: A restart while the counter is strictly greater than the window value sets the error flag, and the counter still reloads. A restart when the counter is at or below the window value does not set the flag.
- R6: Until the mode register is written, reload and window are both 0xFFF, so every restart is legal.
- R7: Mode write layout (`wr_sel`=1):
  - reload is bits [11:0]
  - interrupt enable is bit 12
  - reset enable is bit 13
  - debug-halt enable is bit 14
  - idle-halt enable is bit 15
  - window is bits [27:16]

  Only the first mode write after reset is accepted, and it also restarts the counter with the new reload value. Later mode writes are ignored.
- R8: A one-cycle `rd_clr` pulse clears both flags. A fault in the same cycle as the pulse wins, and its flag stays set.
- R9: `irq` is the interrupt enable ANDed with the OR of the two flags. `wdt_rst` is the reset enable ANDed with the same OR.
- R10: While `dbg_halt` is high and debug-halt is enabled, both the counter and the prescaler are frozen. The same holds for `idle_halt` with idle-halt enabled. A halt input whose enable bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the mode register |
| wr_data | input | 32 | Write data |
| rd_clr | input | 1 | Status read strobe; clears the flags |
| dbg_halt | input | 1 | Debugger halt request |
| idle_halt | input | 1 | Processor idle indication |
| unf_flag | output | 1 | Underflow status flag |
| err_flag | output | 1 | Window error status flag |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | Reset request |
| cnt_value | output | 12 | Current counter value, for test |

## Verification
The hardest case to reach from the ports is a restart that lands on an exact counter value near the window boundary. At the default ratio, reaching such a value takes thousands of clocks, and a one-clock timing slip changes the result. The bench therefore uses a small prescale ratio and re-runs reset plus the mode write before every table vector. It then waits an exact multiple of the ratio, so that each restart is sampled at a known counter value. The values used are above, at and below the window, with good and bad keys.

// File: rtl/winwdog_pkg.sv
// Shared types and constants for the windowed watchdog.
// Assumes a 12-bit counter and a 28-bit mode field image.
package winwdog_pkg;
    localparam int CNT_W = 12;
    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Mode register image, bits [27:0] of a mode write.
    typedef struct packed {
        logic [CNT_W-1:0] window;
        logic             idle_en;
        logic             dbg_en;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/winwdog_presc.sv
// Prescaler: emits a one-cycle tick every DIV clocks.
// Assumes DIV >= 2. The clear input restarts the division, and halt freezes it.
module winwdog_presc #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic halt,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    // Division counter, wrapping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr)
            pcnt <= '0;
        else if (!halt)
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end

    // Tick on the last phase unless frozen or cleared.
    always_comb tick = !halt && !clr && (pcnt == LAST);

    assert_presc_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/winwdog_count.sv
// Down counter with reload. Underflow is a tick taken while at zero.
// Assumes load and tick come from separate logic, and load wins.
module winwdog_count
    import winwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    // Underflow event for the status logic.
    always_comb underflow = tick && !load && (cnt == '0);

    // Counter state update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_MAX;
        else if (load || underflow)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/winwdog_regs.sv
// Register decode: keyed restart, write-once mode register, status flags.
// Assumes one write per cycle, selected by wr_sel.
module winwdog_regs
    import winwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             rd_clr,
    input  logic             unf_evt,
    input  logic [CNT_W-1:0] cnt,
    output mode_t            mode_q,
    output logic             restart,
    output logic             mode_load,
    output logic             unf_flag,
    output logic             err_flag
);
    logic locked;
    logic err_evt;
    logic bad_ctrl;

    // Decode of control and mode writes.
    always_comb begin
        restart   = wr_en && !wr_sel && (wr_data[31:24] == RESTART_KEY) && wr_data[0];
        bad_ctrl  = wr_en && !wr_sel && !restart;
        mode_load = wr_en && wr_sel && !locked;
        err_evt   = restart && (cnt > mode_q.window);
    end

    // Mode register, writable once after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{window: CNT_MAX, idle_en: 1'b0, dbg_en: 1'b0,
                        rst_en: 1'b0, irq_en: 1'b0, reload: CNT_MAX};
            locked <= 1'b0;
        end else if (mode_load) begin
            mode_q <= mode_t'(wr_data[MODE_W-1:0]);
            locked <= 1'b1;
        end
    end

    // Status flags: a fault sets its flag and has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unf_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (unf_evt)     unf_flag <= 1'b1;
            else if (rd_clr) unf_flag <= 1'b0;
            if (err_evt)     err_flag <= 1'b1;
            else if (rd_clr) err_flag <= 1'b0;
        end
    end

    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && wr_sel) |=> $stable(mode_q));
    assert_early_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_flag);
    assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_ctrl && !rd_clr) |=> (err_flag == $past(err_flag)));
    assert_underflow_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> unf_flag);
endmodule

// File: rtl/winwdog.sv
// Windowed watchdog top: ties the prescaler, counter and register decode together.
// Assumes the slow clock is the system clock and reset is synchronous.
module winwdog
    import winwdog_pkg::*;
#(
    parameter int PRESC_DIV = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             rd_clr,
    input  logic             dbg_halt,
    input  logic             idle_halt,
    output logic             unf_flag,
    output logic             err_flag,
    output logic             irq,
    output logic             wdt_rst,
    output logic [CNT_W-1:0] cnt_value
);
    mode_t            mode_q;
    logic             restart, mode_load, tick, unf_evt, halt, load;
    logic [CNT_W-1:0] load_val;

    // Halt gating, reload source selection and fault outputs.
    always_comb begin
        halt     = (mode_q.dbg_en && dbg_halt) || (mode_q.idle_en && idle_halt);
        load     = restart || mode_load;
        load_val = mode_load ? wr_data[CNT_W-1:0] : mode_q.reload;
        irq      = mode_q.irq_en && (unf_flag || err_flag);
        wdt_rst  = mode_q.rst_en && (unf_flag || err_flag);
    end

    winwdog_presc #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(load), .halt(halt), .tick(tick)
    );

    winwdog_count u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(tick), .cnt(cnt_value), .underflow(unf_evt)
    );

    winwdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_clr(rd_clr), .unf_evt(unf_evt), .cnt(cnt_value),
        .mode_q(mode_q), .restart(restart), .mode_load(mode_load),
        .unf_flag(unf_flag), .err_flag(err_flag)
    );

    assert_restart_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_value == $past(mode_q.reload)));
    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(cnt_value));
endmodule

// File: tb/sim_winwdog.sv
`timescale 1ns/1ps
module sim_winwdog;
    localparam int DIV = 4;
    localparam logic [7:0] KEY = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        dbg_halt = 1'b0, idle_halt = 1'b0;
    logic        unf_flag, err_flag, irq, wdt_rst;
    logic [11:0] cnt_value;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    winwdog #(.PRESC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_clr(rd_clr), .dbg_halt(dbg_halt),
        .idle_halt(idle_halt), .unf_flag(unf_flag), .err_flag(err_flag),
        .irq(irq), .wdt_rst(wdt_rst), .cnt_value(cnt_value)
    );

    function automatic logic [31:0] mode_word(input logic [11:0] rl, input logic [11:0] win,
                                              input logic ie, input logic re,
                                              input logic de, input logic ide);
        return {4'h0, win, ide, de, re, ie, rl};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_status();
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
    endtask

    // Each vector holds: wait ticks, control word, expected error flag, expected count.
    localparam int NV = 7;
    localparam logic [52:0] VEC [NV] = '{
        {8'd5,  {KEY, 23'd0, 1'b1}, 1'b1, 12'd20},
        {8'd10, {KEY, 23'd0, 1'b1}, 1'b0, 12'd20},
        {8'd15, {KEY, 23'd0, 1'b1}, 1'b0, 12'd20},
        {8'd9,  {KEY, 23'd0, 1'b1}, 1'b1, 12'd20},
        {8'd12, {8'h5A, 23'd0, 1'b1}, 1'b0, 12'd8},
        {8'd12, {KEY, 23'd0, 1'b0}, 1'b0, 12'd8},
        {8'd0,  {KEY, 23'd0, 1'b1}, 1'b1, 12'd20}
    };

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 cnt", 32'(cnt_value), 32'hFFF);
        chk("R1 flags", {30'd0, unf_flag, err_flag}, 32'd0);
        chk("R1 outs", {30'd0, irq, wdt_rst}, 32'd0);

        // R6 default window: early restart is legal
        repeat (10) @(negedge clk);
        wr(1'b0, {KEY, 23'd0, 1'b1});
        chk("R6 no err", 32'(err_flag), 32'd0);
        chk("R6 cnt", 32'(cnt_value), 32'hFFF);

        // Window table: R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(1'b1, mode_word(12'd20, 12'd10, 1'b1, 1'b1, 1'b0, 1'b0));
            repeat (int'(VEC[i][52:45]) * DIV) @(negedge clk);
            wr(1'b0, VEC[i][44:13]);
            chk("R5 err", 32'(err_flag), 32'(VEC[i][12]));
            chk("R3/R4 cnt", 32'(cnt_value), 32'(VEC[i][11:0]));
            chk("R9 irq", {30'd0, irq, wdt_rst}, {30'd0, VEC[i][12], VEC[i][12]});
        end

        // R7 write-once
        do_reset();
        wr(1'b1, mode_word(12'd20, 12'd20, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(1'b1, mode_word(12'd100, 12'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R7 second ignored", 32'(cnt_value), 32'd20);
        wr(1'b0, {KEY, 23'd0, 1'b1});
        chk("R7 window kept", 32'(err_flag), 32'd0);

        // R2 underflow timing, R9 gating off, R8 clear
        do_reset();
        wr(1'b1, mode_word(12'd3, 12'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        repeat (15) @(negedge clk);
        chk("R2 at zero", {19'd0, unf_flag, cnt_value}, {19'd0, 1'b0, 12'd0});
        @(negedge clk);
        chk("R2 underflow", {19'd0, unf_flag, cnt_value}, {19'd0, 1'b1, 12'd3});
        chk("R9 gated", {30'd0, irq, wdt_rst}, 32'd0);
        clear_status();
        chk("R8 cleared", 32'(unf_flag), 32'd0);

        // R9 enabled outputs on underflow
        do_reset();
        wr(1'b1, mode_word(12'd3, 12'd3, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (16) @(negedge clk);
        chk("R9 irq rst", {30'd0, irq, wdt_rst}, 32'd3);

        // R10 debug halt, then idle without enable
        do_reset();
        wr(1'b1, mode_word(12'd20, 12'd20, 1'b0, 1'b0, 1'b1, 1'b0));
        dbg_halt = 1'b1;
        repeat (40) @(negedge clk);
        chk("R10 dbg frozen", 32'(cnt_value), 32'd20);
        dbg_halt = 1'b0;
        repeat (DIV) @(negedge clk);
        chk("R10 resumes", 32'(cnt_value), 32'd19);
        idle_halt = 1'b1;
        repeat (DIV) @(negedge clk);
        chk("R10 idle not enabled", 32'(cnt_value), 32'd18);
        idle_halt = 1'b0;

        // R10 idle halt enabled
        do_reset();
        wr(1'b1, mode_word(12'd20, 12'd20, 1'b0, 1'b0, 1'b0, 1'b1));
        idle_halt = 1'b1;
        repeat (40) @(negedge clk);
        chk("R10 idle frozen", 32'(cnt_value), 32'd20);
        idle_halt = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule